// File: doc/BRIEF.md
# Window Watchdog with Fail-Safe Escalation

This block supervises a microcontroller from inside a system supervisor chip. After any reset it watches the start-up of the controller with a fixed timeout. If that timeout lapses once, it asks for a system reset and watches start-up again. If it lapses a second time in a row, the block latches into a fail-safe state. Only an external wake event or the block's own power-on reset can clear that state.

The controller services the watchdog with one register write. The write carries a mode code and a period selection. A write that asks for the running mode and has a legal selection moves the block from start-up into window supervision. In window supervision, each write is both a mode request and a watchdog trigger. The block accepts a trigger only when the elapsed time is between half and all of the programmed period. A trigger that is too early, a missing trigger, or a bad code each produce a one-cycle reset request and a return to start-up. The period is one of ten base lengths scaled by one of four prescaler factors. A free-running prescaled tick advances the timer.

Top module: `win_watchdog`

## Requirements
- R1: While reset is applied and right after it is released, the block is in start-up (mode 2'b00), fail-safe is clear, and no reset request is raised.
- R2: In start-up, a tick that arrives when the timer count has reached INIT_TICKS, with no strike recorded, raises one reset request pulse, records a strike, clears the timer and keeps the mode at start-up.
- R3: A second start-up expiry with the strike already recorded enters fail-safe (mode 2'b10, fail-safe flag high) and raises no reset request.
- R4: In start-up, a write with code 2'b01 and a selection below 10 enters normal mode (mode 2'b01) and clears the timer and the strike.
- R5: In normal mode, a legal write is accepted when the count is at least half the period (period >> 1) and at most the period. An accepted write raises no request and restarts the timer from zero.
- R6: In normal mode, a write with count below half the period raises a reset request and returns to start-up.
- R7: In normal mode, a tick that arrives while the count equals the period, with no write in that cycle, raises a reset request and returns to start-up.
- R8: In start-up or normal mode, a write whose code is not 2'b01 or whose selection is 10 or above raises a reset request and leaves or stays in start-up.
- R9: The period in ticks is (sel+1)*BASE_UNIT shifted left by the 2-bit prescaler field (factors 1, 2, 4, 8). It is taken from an accepted write and governs the window from that write on.
- R10: In fail-safe, writes are ignored: no request is raised and the mode stays 2'b10. A wake pulse returns the block to start-up with the strike cleared.
- R11: The timer advances once every TICK_DIV clock cycles. The tick divider restarts together with the timer at every restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wake_i | input | 1 | External wake; leaves fail-safe |
| wr_en_i | input | 1 | Trigger/mode write strobe, one cycle |
| wr_code_i | input | 2 | Requested mode code; 2'b01 is the only legal one |
| wr_sel_i | input | 4 | Base period selection, 0..9 legal |
| wr_pre_i | input | 2 | Prescaler factor exponent |
| rst_req_o | output | 1 | One-cycle system reset request |
| failsafe_o | output | 1 | Fail-safe latched |
| mode_o | output | 2 | Current mode: 00 start-up, 01 normal, 10 fail-safe |

## Verification
The properties take each write to be a single-cycle strobe whose fields are stable in that cycle. They also take the wake input to matter only in fail-safe. The stimulus drives every write for exactly one cycle on the falling edge and asserts wake only once fail-safe is reached. Writes in start-up are spaced far enough apart that a second write never lands in the cycle of the first write's reset request. The window boundaries are hit by counting cycles from the last restart, so the tick phase is known for every write.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int SEL_W = 4;
  localparam int PRE_W = 2;
  localparam int CODE_W = 2;
  localparam logic [CODE_W-1:0] CODE_RUN = 2'b01;

  typedef enum logic [1:0] {
    WM_STARTUP  = 2'b00,
    WM_NORMAL   = 2'b01,
    WM_FAILSAFE = 2'b10
  } wd_mode_e;
endpackage

// File: rtl/wdg_tick_gen.sv
module wdg_tick_gen #(
  parameter int DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic tick_o
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] div_q, div_d;

  always_comb begin
    if (restart_i || div_q == LAST) div_d = '0;
    else                            div_d = div_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else         div_q <= div_d;
  end

  assign tick_o = (div_q == LAST);
endmodule

// File: rtl/wdg_period_lut.sv
module wdg_period_lut
  import wdg_pkg::*;
#(
  parameter int CNT_W     = 12,
  parameter int BASE_UNIT = 4,
  parameter int N_BASE    = 10
) (
  input  logic [SEL_W-1:0] sel_i,
  input  logic [PRE_W-1:0] pre_i,
  output logic [CNT_W-1:0] period_o,
  output logic             sel_ok_o
);
  logic [CNT_W-1:0] tbl [N_BASE];
  logic [CNT_W-1:0] base;

  for (genvar g = 0; g < N_BASE; g++) begin : g_tbl
    assign tbl[g] = CNT_W'((g + 1) * BASE_UNIT);
  end

  always_comb begin
    base = '0;
    for (int i = 0; i < N_BASE; i++) begin
      if (sel_i == SEL_W'(i)) base = tbl[i];
    end
  end

  assign sel_ok_o = (int'(sel_i) < N_BASE);
  assign period_o = base << pre_i;
endmodule

// File: rtl/wdg_window_chk.sv
module wdg_window_chk #(
  parameter int CNT_W = 12
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] period_i,
  output logic             early_o,
  output logic             due_o
);
  logic [CNT_W-1:0] half;

  assign half    = period_i >> 1;
  assign early_o = (cnt_i < half);
  assign due_o   = (cnt_i >= period_i);
endmodule

// File: rtl/win_watchdog.sv
module win_watchdog
  import wdg_pkg::*;
#(
  parameter int TICK_DIV   = 2,
  parameter int BASE_UNIT  = 4,
  parameter int N_BASE     = 10,
  parameter int INIT_TICKS = 16,
  parameter int CNT_W      = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wake_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_code_i,
  input  logic [3:0]        wr_sel_i,
  input  logic [1:0]        wr_pre_i,
  output logic              rst_req_o,
  output logic              failsafe_o,
  output logic [1:0]        mode_o
);
  localparam logic [CNT_W-1:0] INIT_LIM = CNT_W'(INIT_TICKS);

  wd_mode_e         mode_q, mode_d;
  logic             strike_q, strike_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] period_q, period_d;
  logic             req_q, req_d;
  logic             restart;
  logic             tick;
  logic [CNT_W-1:0] new_period;
  logic             sel_ok;
  logic             wr_ok;
  logic             win_early;
  logic             win_due;

  wdg_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart),
    .tick_o    (tick)
  );

  wdg_period_lut #(
    .CNT_W     (CNT_W),
    .BASE_UNIT (BASE_UNIT),
    .N_BASE    (N_BASE)
  ) u_lut (
    .sel_i    (wr_sel_i),
    .pre_i    (wr_pre_i),
    .period_o (new_period),
    .sel_ok_o (sel_ok)
  );

  wdg_window_chk #(.CNT_W(CNT_W)) u_win (
    .cnt_i    (cnt_q),
    .period_i (period_q),
    .early_o  (win_early),
    .due_o    (win_due)
  );

  assign wr_ok = wr_en_i && (wr_code_i == CODE_RUN) && sel_ok;

  always_comb begin
    mode_d   = mode_q;
    strike_d = strike_q;
    period_d = period_q;
    req_d    = 1'b0;
    restart  = 1'b0;
    cnt_d    = tick ? cnt_q + 1'b1 : cnt_q;
    unique case (mode_q)
      WM_STARTUP: begin
        if (wr_en_i) begin
          restart = 1'b1;
          cnt_d   = '0;
          if (wr_ok) begin
            mode_d   = WM_NORMAL;
            period_d = new_period;
            strike_d = 1'b0;
          end else begin
            req_d = 1'b1;
          end
        end else if (tick && cnt_q >= INIT_LIM) begin
          restart = 1'b1;
          cnt_d   = '0;
          if (strike_q) begin
            mode_d = WM_FAILSAFE;
          end else begin
            strike_d = 1'b1;
            req_d    = 1'b1;
          end
        end
      end
      WM_NORMAL: begin
        if (wr_en_i || (tick && win_due)) begin
          restart = 1'b1;
          cnt_d   = '0;
          if (wr_ok && !win_early) begin
            period_d = new_period;
          end else begin
            req_d    = 1'b1;
            mode_d   = WM_STARTUP;
            strike_d = 1'b0;
          end
        end
      end
      WM_FAILSAFE: begin
        cnt_d = cnt_q;
        if (wake_i) begin
          restart  = 1'b1;
          cnt_d    = '0;
          mode_d   = WM_STARTUP;
          strike_d = 1'b0;
        end
      end
      default: begin
        restart = 1'b1;
        cnt_d   = '0;
        mode_d  = WM_STARTUP;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= WM_STARTUP;
      strike_q <= 1'b0;
      cnt_q    <= '0;
      period_q <= '0;
      req_q    <= 1'b0;
    end else begin
      mode_q   <= mode_d;
      strike_q <= strike_d;
      cnt_q    <= cnt_d;
      period_q <= period_d;
      req_q    <= req_d;
    end
  end

  assign rst_req_o  = req_q;
  assign failsafe_o = (mode_q == WM_FAILSAFE);
  assign mode_o     = mode_q;
endmodule

// File: rtl/wdg_checker.sv
module wdg_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wake_i,
  input logic       wr_en_i,
  input logic       wr_ok,
  input logic       early,
  input logic       rst_req_o,
  input logic       failsafe_o,
  input logic [1:0] mode_o
);
  a_r10_failsafe_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'b10 && !wake_i) |=> (mode_o == 2'b10));

  a_r10_failsafe_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'b10) |=> !rst_req_o);

  a_r6_early_resets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'b01 && wr_en_i && early) |=> (rst_req_o && mode_o == 2'b00));

  a_r8_bad_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o != 2'b10 && wr_en_i && !wr_ok) |=> (rst_req_o && mode_o == 2'b00));

  a_r5_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'b01 && wr_ok && !early) |=> (!rst_req_o && mode_o == 2'b01));

  a_r4_normal_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mode_o == 2'b01) |-> $past(wr_ok));

  a_r3_failsafe_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(failsafe_o) |-> ($past(mode_o) == 2'b00 && !rst_req_o));
endmodule

bind win_watchdog wdg_checker u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wake_i     (wake_i),
  .wr_en_i    (wr_en_i),
  .wr_ok      (wr_ok),
  .early      (win_early),
  .rst_req_o  (rst_req_o),
  .failsafe_o (failsafe_o),
  .mode_o     (mode_o)
);

// File: tb/win_watchdog_tb.sv
module win_watchdog_tb;
  logic       clk;
  logic       rst_n;
  logic       wake;
  logic       wr_en;
  logic [1:0] wr_code;
  logic [3:0] wr_sel;
  logic [1:0] wr_pre;
  logic       rst_req;
  logic       fs;
  logic [1:0] mode;

  int total = 0;
  int bad = 0;
  int pulses = 0;
  int cycles = 0;

  win_watchdog u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .wake_i     (wake),
    .wr_en_i    (wr_en),
    .wr_code_i  (wr_code),
    .wr_sel_i   (wr_sel),
    .wr_pre_i   (wr_pre),
    .rst_req_o  (rst_req),
    .failsafe_o (fs),
    .mode_o     (mode)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (rst_n && rst_req) pulses <= pulses + 1;
  end

  always @(posedge clk) begin
    if (cycles > 20000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: run hung, actual=%0d expected<=20000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // called on a falling edge; returns on the falling edge after the sampling edge
  task automatic do_write(logic [1:0] code, logic [3:0] sel, logic [1:0] pre);
    wr_en = 1'b1; wr_code = code; wr_sel = sel; wr_pre = pre;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic enter_normal(logic [3:0] sel, logic [1:0] pre);
    do_write(2'b01, sel, pre);
    chk("R4 mode after valid start-up write", int'(mode), 1);
    chk("R4 no request on entry", int'(rst_req), 0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; wake = 1'b0; wr_en = 1'b0; wr_code = '0; wr_sel = '0; wr_pre = '0;
    idle(3);
    chk("R1 mode in reset", int'(mode), 0);
    chk("R1 fail-safe in reset", int'(fs), 0);
    rst_n = 1'b1;
    idle(1);
    chk("R1 no request after release", int'(rst_req), 0);
  endtask

  task automatic t_escalation;
    int p0;
    p0 = pulses;
    idle(50);
    chk("R2 one request after first expiry", pulses - p0, 1);
    chk("R2 still start-up", int'(mode), 0);
    idle(50);
    chk("R3 fail-safe flag", int'(fs), 1);
    chk("R3 fail-safe mode", int'(mode), 2);
    chk("R3 no extra request", pulses - p0, 1);
  endtask

  task automatic t_failsafe;
    int p0;
    p0 = pulses;
    do_write(2'b01, 4'd0, 2'd0);
    idle(2);
    chk("R10 write ignored, mode", int'(mode), 2);
    chk("R10 write ignored, no request", pulses - p0, 0);
    wake = 1'b1;
    @(negedge clk);
    wake = 1'b0;
    chk("R10 wake leaves fail-safe", int'(mode), 0);
    chk("R10 flag clear after wake", int'(fs), 0);
  endtask

  // period 4 ticks, half 2, tick every 2 cycles (R11): write at edge E+d sees count (d-1)/2
  task automatic t_window;
    enter_normal(4'd0, 2'd0);
    idle(4); do_write(2'b01, 4'd0, 2'd0);
    chk("R5 accept at half (R11 tick rate)", int'(mode), 1);
    chk("R5 no request at half", int'(rst_req), 0);
    idle(9); do_write(2'b01, 4'd0, 2'd0);
    chk("R5 accept at full period", int'(mode), 1);
    chk("R5 no request at full", int'(rst_req), 0);
    idle(3); do_write(2'b01, 4'd0, 2'd0);
    chk("R6 early write request", int'(rst_req), 1);
    chk("R6 early write back to start-up", int'(mode), 0);
  endtask

  task automatic t_timeout;
    idle(3);
    enter_normal(4'd0, 2'd0);
    idle(9);
    chk("R7 no request before expiry", int'(rst_req), 0);
    idle(1);
    chk("R7 request at expiry", int'(rst_req), 1);
    chk("R7 back to start-up", int'(mode), 0);
  endtask

  task automatic t_bad_code;
    idle(3);
    enter_normal(4'd0, 2'd0);
    idle(4); do_write(2'b10, 4'd0, 2'd0);
    chk("R8 bad code request", int'(rst_req), 1);
    chk("R8 bad code to start-up", int'(mode), 0);
    idle(3); do_write(2'b01, 4'd12, 2'd0);
    chk("R8 bad selection request in start-up", int'(rst_req), 1);
    chk("R8 bad selection stays start-up", int'(mode), 0);
  endtask

  task automatic t_period;
    idle(3);
    enter_normal(4'd0, 2'd1);
    idle(7); do_write(2'b01, 4'd0, 2'd0);
    chk("R9 prescaled half not reached", int'(rst_req), 1);
    idle(3);
    enter_normal(4'd0, 2'd1);
    idle(8); do_write(2'b01, 4'd1, 2'd0);
    chk("R9 prescaled window accepted", int'(rst_req), 0);
    chk("R9 prescaled window mode", int'(mode), 1);
    idle(7); do_write(2'b01, 4'd0, 2'd0);
    chk("R9 new selection sets half", int'(rst_req), 1);
  endtask

  initial begin
    t_reset();
    t_escalation();
    t_failsafe();
    t_window();
    t_timeout();
    t_bad_code();
    t_period();
    idle(2);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule